// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block turns bytes written by a host into an asynchronous serial stream. It has two byte stores. A holding register takes the host's writes. A shift register drives the line. Because of this, the host can deposit the next byte while the current one is still leaving. A flag tells the host when the holding register is free. The host writes a byte, and the flag drops. The flag rises again as soon as the transmitter has taken that byte into the shift register.

Each frame is one low start bit, then the data bits least significant first, then one high stop bit. Bit timing comes from an external one-cycle enable pulse, one pulse per bit time, supplied by a baud generator outside the block. The line and the state machine move only on clock edges where that pulse is high. Host writes are taken on any clock edge. A new frame starts on an enable edge only when the transmitter is idle or is ending a stop bit, and only if a byte is waiting.

Top module: `uart_dbuf_tx`

## Requirements
- R1: While no frame is in progress, `txd` is 1.
- R2: On an enable edge where the transmitter is idle or ending a stop bit and `hold_empty` is 0, `txd` becomes 0 (start bit) after that edge. It stays 0 until the next enable edge.
- R3: After the start bit, the 8 bits of the byte go out one per bit time, bit 0 first and bit 7 last. Each bit appears after an enable edge and is held until the next one.
- R4: After bit 7, `txd` is 1 for at least one bit time (stop bit). If no byte is waiting at the end of the stop bit, the line stays 1 (idle).
- R5: A clock edge with `wr_strobe` = 1 loads `wr_data` into the holding register, and `hold_empty` reads 0 after that edge.
- R6: The edge that starts a frame copies the holding register into the shift register, and `hold_empty` reads 1 after that edge, unless R8 applies. `hold_empty` never rises without such a transfer.
- R7: `txd` changes only after clock edges where `bit_tick` is 1. A host write during a frame does not disturb the byte being sent.
- R8: If a write and a transfer happen on the same edge, the previously held byte is sent, the new byte is held, and `hold_empty` reads 0.
- R9: While `rst_n` is 0 at a clock edge, the block goes idle after that edge, with `txd` = 1 and `hold_empty` = 1.
- R10: If a byte is waiting when a stop bit ends, the next start bit follows directly, so the stop bit lasts exactly one bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_strobe | input | 1 | Host write, one cycle per byte |
| wr_data | input | 8 | Byte written by the host |
| bit_tick | input | 1 | One-cycle pulse, one per bit time |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | 1 when the holding register can take a byte |

## Verification
Each result appears in the first cycle after the edge that causes it:
- a write clears `hold_empty` after its own edge;
- an enable edge that starts a frame drives the start bit and sets `hold_empty` after that same edge;
- every later bit changes only after an enable edge.

The bench keeps a behavioural model that it updates at each rising edge from the inputs it drove. It compares `txd` and `hold_empty` against that model at the following falling edge, so every output is checked exactly one edge after its cause.

The stimulus runs at several enable spacings, including an enable on every cycle. It includes writes that arrive on the same edge as a transfer, writes that overwrite a byte still waiting, and streams of frames sent back to back.

// File: rtl/uart_dbuf_pkg.sv
// Package: shared types for the double-buffered transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_dbuf_pkg;

    // Frame sequencer phases, one per kind of bit on the line
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_phase_e;

endpackage

// File: rtl/tx_hold_reg.sv
// Module: tx_hold_reg
// Holds one host byte and the empty flag.
// Assumes: take_byte is raised only while the flag is 0; a write on the
// same edge as take_byte wins the flag, and the old byte goes out.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take_byte,
    output logic [DATA_W-1:0] held_byte,
    output logic              is_empty
);

    // Byte store: load on every host write
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_byte <= '0;
        else if (wr_strobe)
            held_byte <= wr_data;
    end

    // Empty flag: write clears it, transfer sets it, write has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_empty <= 1'b1;
        else if (wr_strobe)
            is_empty <= 1'b0;
        else if (take_byte)
            is_empty <= 1'b1;
    end

    p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !is_empty);

    p_transfer_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && !wr_strobe) |=> is_empty);

    p_overlap_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && wr_strobe) |=> (!is_empty && held_byte == $past(wr_data)));

endmodule

// File: rtl/tx_frame_fsm.sv
// Module: tx_frame_fsm
// Sends one frame per transfer: start bit, data bits LSB first, stop bit.
// Assumes: bit_tick is a one-cycle pulse per bit time; byte_ready is the
// inverted empty flag of the holding register.
module tx_frame_fsm
    import uart_dbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              byte_ready,
    input  logic [DATA_W-1:0] next_byte,
    output logic              take_byte,
    output logic              txd
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_phase_e         phase;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              frame_gap;

    // A new frame may begin while idle or at the end of a stop bit
    assign frame_gap = (phase == TX_IDLE) || (phase == TX_STOP);
    assign take_byte = bit_tick && frame_gap && byte_ready;

    // Sequencer: advance phase, shift and line value on each bit enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= TX_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            txd     <= 1'b1;
        end else if (bit_tick) begin
            unique case (phase)
                TX_IDLE, TX_STOP: begin
                    if (byte_ready) begin
                        shreg <= next_byte;
                        txd   <= 1'b0;
                        phase <= TX_START;
                    end else begin
                        txd   <= 1'b1;
                        phase <= TX_IDLE;
                    end
                end
                TX_START: begin
                    txd     <= shreg[0];
                    shreg   <= shreg >> 1;
                    bit_cnt <= '0;
                    phase   <= TX_DATA;
                end
                TX_DATA: begin
                    if (bit_cnt == LAST_BIT) begin
                        txd   <= 1'b1;
                        phase <= TX_STOP;
                    end else begin
                        txd     <= shreg[0];
                        shreg   <= shreg >> 1;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: phase <= TX_IDLE;
            endcase
        end
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == TX_IDLE) |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_byte |=> (!txd && phase == TX_START));

    p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == TX_STOP) |-> txd);

    p_line_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

endmodule

// File: rtl/uart_dbuf_tx.sv
// Module: uart_dbuf_tx (top)
// Double-buffered serial transmitter: host byte store plus frame sequencer.
// Assumes: bit_tick comes from an external baud generator; reset is
// synchronous and active low.
module uart_dbuf_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_tick,
    output logic              txd,
    output logic              hold_empty
);

    logic [DATA_W-1:0] held_byte;
    logic              take_byte;

    // Host-side byte store and empty flag
    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .take_byte (take_byte),
        .held_byte (held_byte),
        .is_empty  (hold_empty)
    );

    // Line-side frame sequencer
    tx_frame_fsm #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .byte_ready (!hold_empty),
        .next_byte  (held_byte),
        .take_byte  (take_byte),
        .txd        (txd)
    );

    p_take_needs_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_byte |-> !hold_empty);

endmodule

// File: tb/test_uart_dbuf_tx.sv
// Bench: behavioural line model updated on each rising edge, compared on
// each falling edge.
module test_uart_dbuf_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       hold_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_dbuf_tx i_uart_dbuf_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (wr_strobe),
        .wr_data    (wr_data),
        .bit_tick   (bit_tick),
        .txd        (txd),
        .hold_empty (hold_empty)
    );

    // Model state: pos -1 idle, 0 start, 1..8 data, 9 stop
    int       pos = -1;
    bit [7:0] m_hold = 8'h00;
    bit [7:0] m_cur = 8'h00;
    bit       m_empty = 1'b1;
    bit       l_wr = 1'b0, l_xfer = 1'b0, l_tick = 1'b0, l_b2b = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pos = -1; m_empty = 1'b1; m_hold = 8'h00;
            l_wr = 1'b0; l_xfer = 1'b0; l_tick = 1'b0; l_b2b = 1'b0;
        end else begin
            l_xfer = 1'b0; l_b2b = 1'b0;
            if (bit_tick) begin
                if (pos == -1 || pos == 9) begin
                    if (!m_empty) begin
                        l_b2b = (pos == 9);
                        m_cur = m_hold; pos = 0; l_xfer = 1'b1;
                    end else pos = -1;
                end else pos = pos + 1;
            end
            if (l_xfer) m_empty = 1'b1;
            if (wr_strobe) begin m_hold = wr_data; m_empty = 1'b0; end
            l_wr = wr_strobe; l_tick = bit_tick;
        end
    end

    function automatic bit exp_line();
        if (pos == -1 || pos == 9) return 1'b1;
        if (pos == 0) return 1'b0;
        return m_cur[pos-1];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Compare both outputs against the model for this cycle
    task automatic compare();
        string rq;
        if (!l_tick)          rq = "R7";
        else if (l_b2b)       rq = "R10";
        else if (pos == -1)   rq = "R1";
        else if (pos == 0)    rq = "R2";
        else if (pos == 9)    rq = "R4";
        else                  rq = "R3";
        check(txd == exp_line(), rq, txd, exp_line());
        if (l_wr && l_xfer)   rq = "R8";
        else if (l_wr)        rq = "R5";
        else                  rq = "R6";
        check(hold_empty == m_empty, rq, hold_empty, m_empty);
    endtask

    task automatic run_phase(input int period, input int cycles, input int wr_pct, input bit any_time);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare();
            bit_tick  = (c % period) == 0;
            wr_strobe = (any_time || m_empty) && ($urandom_range(99) < wr_pct);
            wr_data   = 8'($urandom_range(255));
        end
    endtask

    initial begin
        // R9: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(txd == 1'b1, "R9", txd, 1);
        check(hold_empty == 1'b1, "R9", hold_empty, 1);
        rst_n = 1'b1;
        run_phase(4, 3000, 30, 1'b0);
        run_phase(1, 2000, 50, 1'b0);
        run_phase(7, 4000, 20, 1'b1);
        run_phase(3, 3000, 90, 1'b1);
        run_phase(5, 2000, 2, 1'b0);
        // R9: reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0; wr_strobe = 1'b0; bit_tick = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R9", txd, 1);
        check(hold_empty == 1'b1, "R9", hold_empty, 1);
        rst_n = 1'b1;
        run_phase(2, 1000, 40, 1'b1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule